// File: doc/BRIEF.md
# Invert-Controlled Arithmetic Logic Unit with Operation Decoder

This block is a purely combinational integer datapath element. It takes two operands and returns one of six results: bitwise AND, bitwise OR, bitwise NOR, sum, difference, or a signed less-than indication. The block has no separate unit for each operation. Instead, a 4-bit control word can invert either operand. The inverted or plain operands then drive one shared set of AND, OR and adder logic, and a result selector picks which output to pass. Subtraction is the adder with operand B inverted and a carry-in of one. NOR is the AND of both inverted operands.

A small decoder in front of the datapath builds the control word. Its inputs are a 2-bit operation class from the main instruction control and a 6-bit function code from the instruction word. Memory-access instructions get an add to form the address. Equality branches get a subtract, and the zero flag then tests for equality. Register-to-register instructions take their operation from the function code. The control word also appears as an output, so that nearby logic can observe which operation was chosen.

A parameter selects the carry structure. The carry can ripple through every bit, or it can skip across fixed-size groups using group generate and propagate terms. The arithmetic result is identical in both variants.

Top module: `inv_alu`

## Requirements
- R1: The control word is {invert A, invert B, leg[1:0]}, with leg 00 = AND, 01 = OR, 10 = adder, 11 = less-than. The six legal words are AND 0000, OR 0001, add 0010, subtract 0110, set-less-than 0111 and NOR 1100. The decoder emits only these, and they appear on `ctrl_word`.
- R2: Operation class 00 gives the add word and class 01 gives the subtract word, whatever the function code. Class 11 gives the add word.
- R3: In class 10 the function code sets the word: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x27 NOR, 0x2A set-less-than. Every other code gives the add word.
- R4: The AND, OR and NOR words return the bitwise A&B, A|B and ~(A|B) on all WIDTH bits.
- R5: The add word returns A+B modulo 2^WIDTH. `carry_out` is the unsigned carry out of the top bit.
- R6: The subtract word returns A−B modulo 2^WIDTH, formed by inverting B with carry-in 1. `carry_out` is 1 exactly when A ≥ B as unsigned numbers.
- R7: The set-less-than word returns 1 in bit 0 when A < B as signed numbers and 0 otherwise. All other bits are 0. The comparison is correct even when A−B overflows.
- R8: `zero` is 1 exactly when every result bit is 0. Under the subtract word, it is 1 exactly when A equals B.
- R9: `overflow` is the signed overflow of the sum or difference (carry into the top bit XOR carry out of it), and is raised only for the add and subtract words. `overflow` and `carry_out` are 0 for the AND, OR, NOR and set-less-than words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main control |
| funct | input | 6 | Function code, used when op_class is 10 |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| ctrl_word | output | 4 | Decoded control word {invert A, invert B, leg} |
| result | output | WIDTH | Selected result |
| zero | output | 1 | All result bits are zero |
| carry_out | output | 1 | Carry out of the top bit (adder leg only) |
| overflow | output | 1 | Signed overflow (adder leg only) |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the inputs that expose it. A wrong decode entry appears at once on `ctrl_word` and in the result value. A wrong carry-in or a broken group carry corrupts the sum only for operands whose carry actually travels across the faulty position. For this reason the operands include the all-ones, sign-boundary and random patterns that drive carries along the whole width. A less-than path that ignores overflow gives the wrong answer only when the difference overflows. The most-negative and most-positive operand pairs are chosen to reach that case.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;

   // control word layout: {invert A, invert B, result leg}
   typedef struct packed {
      logic       inv_a;
      logic       inv_b;
      logic [1:0] leg;
   } alu_ctrl_t;

   localparam logic [1:0] LEG_AND  = 2'b00;
   localparam logic [1:0] LEG_OR   = 2'b01;
   localparam logic [1:0] LEG_SUM  = 2'b10;
   localparam logic [1:0] LEG_LESS = 2'b11;

   localparam logic [3:0] CW_AND = 4'b0000;
   localparam logic [3:0] CW_OR  = 4'b0001;
   localparam logic [3:0] CW_ADD = 4'b0010;
   localparam logic [3:0] CW_SUB = 4'b0110;
   localparam logic [3:0] CW_SLT = 4'b0111;
   localparam logic [3:0] CW_NOR = 4'b1100;

   localparam logic [1:0] CLS_MEM    = 2'b00;
   localparam logic [1:0] CLS_BRANCH = 2'b01;
   localparam logic [1:0] CLS_FUNC   = 2'b10;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_NOR = 6'h27;
   localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/inv_alu_decode.sv
module inv_alu_decode
   import inv_alu_pkg::*;
(
   input  logic [1:0] op_class,
   input  logic [5:0] funct,
   output alu_ctrl_t  ctrl
);

   logic [3:0] word;

   always_comb begin
      word = CW_ADD;
      unique case (op_class)
         CLS_MEM:    word = CW_ADD;
         CLS_BRANCH: word = CW_SUB;
         CLS_FUNC: begin
            case (funct)
               FN_ADD:  word = CW_ADD;
               FN_SUB:  word = CW_SUB;
               FN_AND:  word = CW_AND;
               FN_OR:   word = CW_OR;
               FN_NOR:  word = CW_NOR;
               FN_SLT:  word = CW_SLT;
               default: word = CW_ADD;
            endcase
         end
         default:    word = CW_ADD;
      endcase
   end

   assign ctrl = word;

   // R1: only the six legal words ever leave the decoder
   always_comb begin
      assert_legal_word_R1: assert (ctrl == CW_AND || ctrl == CW_OR || ctrl == CW_ADD ||
                                    ctrl == CW_SUB || ctrl == CW_SLT || ctrl == CW_NOR)
         else $error("illegal control word %b", ctrl);
   end

endmodule

// File: rtl/inv_alu_operand.sv
module inv_alu_operand
   import inv_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  alu_ctrl_t        ctrl,
   output logic [WIDTH-1:0] gen,
   output logic [WIDTH-1:0] prop,
   output logic             cin
);

   logic [WIDTH-1:0] a_eff;
   logic [WIDTH-1:0] b_eff;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign a_eff[i] = opa[i] ^ ctrl.inv_a;
         assign b_eff[i] = opb[i] ^ ctrl.inv_b;
         assign gen[i]   = a_eff[i] & b_eff[i];
         assign prop[i]  = a_eff[i] ^ b_eff[i];
      end
   endgenerate

   // inverting B plus a carry-in of one forms the two's complement
   assign cin = ctrl.inv_b;

endmodule

// File: rtl/inv_alu_carry.sv
module inv_alu_carry #(
   parameter int WIDTH = 32,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] gen,
   input  logic [WIDTH-1:0] prop,
   input  logic             cin,
   output logic [WIDTH:0]   carry
);

   localparam int NGRP = (GROUP > 1) ? WIDTH / GROUP : WIDTH;

   generate
      if (WIDTH < 2) begin : g_chk_width
         $error("inv_alu_carry: WIDTH must be at least 2");
      end
      if (GROUP < 1) begin : g_chk_group
         $error("inv_alu_carry: GROUP must be at least 1");
      end
      if (GROUP > 1 && (WIDTH % GROUP) != 0) begin : g_chk_div
         $error("inv_alu_carry: WIDTH must be a multiple of GROUP");
      end
   endgenerate

   assign carry[0] = cin;

   genvar i, k, j;
   generate
      if (GROUP <= 1) begin : g_ripple
         for (i = 0; i < WIDTH; i++) begin : g_bit
            assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
         end
      end else begin : g_grouped
         logic [NGRP:0] gcar;
         assign gcar[0] = cin;
         for (k = 0; k < NGRP; k++) begin : g_grp
            logic [GROUP:0] gg;
            logic [GROUP:0] pp;
            assign gg[0] = 1'b0;
            assign pp[0] = 1'b1;
            for (j = 0; j < GROUP; j++) begin : g_term
               assign gg[j+1] = gen[k*GROUP+j] | (prop[k*GROUP+j] & gg[j]);
               assign pp[j+1] = pp[j] & prop[k*GROUP+j];
            end
            // group carry skips over the bits of the group
            assign gcar[k+1] = gg[GROUP] | (pp[GROUP] & gcar[k]);
            assign carry[(k+1)*GROUP] = gcar[k+1];
            // inner bits ripple from the group carry-in
            for (j = 0; j < GROUP - 1; j++) begin : g_inner
               assign carry[k*GROUP+j+1] = gen[k*GROUP+j] | (prop[k*GROUP+j] & carry[k*GROUP+j]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/inv_alu_result.sv
module inv_alu_result
   import inv_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_ctrl_t        ctrl,
   input  logic [WIDTH-1:0] gen,
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH:0]   carry,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             carry_out,
   output logic             overflow
);

   logic [WIDTH-1:0] sum;
   logic             ovf_raw;
   logic             less;

   assign sum     = prop ^ carry[WIDTH-1:0];
   assign ovf_raw = carry[WIDTH] ^ carry[WIDTH-1];
   // sign of the difference, corrected when the difference overflowed
   assign less    = sum[WIDTH-1] ^ ovf_raw;

   always_comb begin
      unique case (ctrl.leg)
         LEG_AND:  result = gen;
         LEG_OR:   result = gen | prop;
         LEG_SUM:  result = sum;
         LEG_LESS: result = {{(WIDTH-1){1'b0}}, less};
         default:  result = '0;
      endcase
   end

   assign zero      = ~|result;
   assign carry_out = (ctrl.leg == LEG_SUM) & carry[WIDTH];
   assign overflow  = (ctrl.leg == LEG_SUM) & ovf_raw;

   // R7: the less-than leg never drives upper result bits
   always_comb begin
      if (ctrl.leg == LEG_LESS) begin
         assert_slt_upper_clear_R7: assert (result[WIDTH-1:1] == '0)
            else $error("set-less-than upper bits not clear");
      end
   end

endmodule

// File: rtl/inv_alu.sv
module inv_alu
   import inv_alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int CARRY_GROUP = 4
) (
   input  logic [1:0]       op_class,
   input  logic [5:0]       funct,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [3:0]       ctrl_word,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             carry_out,
   output logic             overflow
);

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] prop;
   logic             cin;
   logic [WIDTH:0]   carry;

   inv_alu_decode u_decode (
      .op_class (op_class),
      .funct    (funct),
      .ctrl     (ctrl)
   );

   inv_alu_operand #(.WIDTH(WIDTH)) u_operand (
      .opa  (opa),
      .opb  (opb),
      .ctrl (ctrl),
      .gen  (gen),
      .prop (prop),
      .cin  (cin)
   );

   inv_alu_carry #(.WIDTH(WIDTH), .GROUP(CARRY_GROUP)) u_carry (
      .gen   (gen),
      .prop  (prop),
      .cin   (cin),
      .carry (carry)
   );

   inv_alu_result #(.WIDTH(WIDTH)) u_result (
      .ctrl      (ctrl),
      .gen       (gen),
      .prop      (prop),
      .carry     (carry),
      .result    (result),
      .zero      (zero),
      .carry_out (carry_out),
      .overflow  (overflow)
   );

   assign ctrl_word = ctrl;

   // operand-level checks across decoder, carry network and result selector
   always_comb begin
      if (ctrl_word == CW_ADD) begin
         assert_add_sum_R5: assert (result == opa + opb)
            else $error("add result mismatch");
      end
      if (ctrl_word == CW_SUB) begin
         assert_sub_diff_R6: assert (result == opa - opb)
            else $error("subtract result mismatch");
         assert_beq_zero_R8: assert (zero == (opa == opb))
            else $error("zero flag disagrees with operand equality");
      end
      if (ctrl_word[1] == 1'b0 || ctrl_word[0] == 1'b1) begin
         assert_flags_quiet_R9: assert (!overflow && !carry_out)
            else $error("flags raised outside the adder leg");
      end
   end

endmodule

// File: tb/test_inv_alu.sv
module test_inv_alu;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic [1:0]    op_class = '0;
   logic [5:0]    funct = '0;
   logic [W-1:0]  opa = '0;
   logic [W-1:0]  opb = '0;
   logic [3:0]    ctrl_word;
   logic [W-1:0]  result;
   logic          zero, carry_out, overflow;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit driving = 1'b1;

   typedef struct {
      logic [1:0]   cls;
      logic [3:0]   cw;
      logic [W-1:0] res;
      logic         z, c, v;
   } exp_t;

   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   inv_alu #(.WIDTH(W), .CARRY_GROUP(4)) i_inv_alu (
      .op_class (op_class), .funct (funct), .opa (opa), .opb (opb),
      .ctrl_word (ctrl_word), .result (result), .zero (zero),
      .carry_out (carry_out), .overflow (overflow)
   );

   function automatic logic [3:0] ref_word(input logic [1:0] c, input logic [5:0] f);
      if (c == 2'b01) return 4'b0110;
      if (c != 2'b10) return 4'b0010;
      case (f)
         6'h22:   return 4'b0110;
         6'h24:   return 4'b0000;
         6'h25:   return 4'b0001;
         6'h27:   return 4'b1100;
         6'h2A:   return 4'b0111;
         default: return 4'b0010;
      endcase
   endfunction

   task automatic drive(input logic [1:0] c, input logic [5:0] f,
                        input logic [W-1:0] a, input logic [W-1:0] b);
      exp_t e;
      logic [W:0] wide;
      @(posedge clk);
      #1;
      op_class = c; funct = f; opa = a; opb = b;
      e.cls = c;
      e.cw  = ref_word(c, f);
      e.c = 1'b0; e.v = 1'b0;
      case (e.cw)
         4'b0000: e.res = a & b;
         4'b0001: e.res = a | b;
         4'b1100: e.res = ~(a | b);
         4'b0111: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'b0110: begin
            e.res = a - b;
            e.c   = (a >= b);
            e.v   = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
         end
         default: begin
            wide  = {1'b0, a} + {1'b0, b};
            e.res = wide[W-1:0];
            e.c   = wide[W];
            e.v   = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
         end
      endcase
      e.z = (e.res == '0);
      sb_q.push_back(e);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle, away from the driving edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         string rtag;
         e = sb_q.pop_front();
         check(ctrl_word == e.cw, (e.cls == 2'b10) ? "R3" : "R2", "decode",
               {28'd0, ctrl_word}, {28'd0, e.cw});
         check(ctrl_word == e.cw, "R1", "control word", {28'd0, ctrl_word}, {28'd0, e.cw});
         case (e.cw)
            4'b0010: rtag = "R5";
            4'b0110: rtag = "R6";
            4'b0111: rtag = "R7";
            default: rtag = "R4";
         endcase
         check(result == e.res, rtag, "result", result, e.res);
         check(zero == e.z, "R8", "zero", {31'd0, zero}, {31'd0, e.z});
         check(carry_out == e.c, (e.cw == 4'b0110) ? "R6" : "R9", "carry",
               {31'd0, carry_out}, {31'd0, e.c});
         check(overflow == e.v, "R9", "overflow", {31'd0, overflow}, {31'd0, e.v});
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   logic [W-1:0] corner [5];
   logic [5:0]   fns [6];

   initial begin
      corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'h8000_0000;
      corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h0000_0001;
      fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24;
      fns[3] = 6'h25; fns[4] = 6'h27; fns[5] = 6'h2A;

      // idle inputs: add of zeros gives zero result with flags low
      drive(2'b00, 6'h00, '0, '0);
      // R2 R3: every class with every function code
      for (int c = 0; c < 4; c++)
         for (int f = 0; f < 64; f++)
            drive(2'(c), 6'(f), corner[(c + f) % 5] ^ 32'h1234_5678, corner[f % 5]);
      // R4..R9: every operation on every corner pair, including overflow cases
      for (int f = 0; f < 6; f++)
         for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++)
               drive(2'b10, fns[f], corner[x], corner[y]);
      // R8: equal operands under branch class
      drive(2'b01, 6'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
      drive(2'b01, 6'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
      // random operands across all operations
      for (int n = 0; n < 1200; n++)
         drive(2'b10, fns[n % 6], $urandom, (n % 7 == 0) ? $urandom & 32'h0000_00FF : $urandom);
      @(posedge clk);
      @(posedge clk);
      driving = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule